// File: doc/BRIEF.md
# Auto-Incrementing Serial Memory Read Engine

This block is the function-command stage of a single-wire slave. It takes over once the net-address layer has selected the device. The master first writes an 8-bit opcode. If the opcode is the read command, the master then writes an 8-bit start address. From that point the block returns memory contents one bit per read slot. Each byte goes out least significant bit first. The address moves on by itself after the last bit of every byte.

The bit-slot timing itself belongs to the address layer, which shares its slot strobe with this block. Each slot is one pulse on `slot_i`. In a write slot the pulse carries the master's bit on `wr_bit_i`. In a read slot the block presents its bit on `tx_bit_o` before the pulse, and the pulse moves the stream on by one bit. The bytes come from an external memory through a synchronous read port. A bus reset abandons the command at any bit. Once the stream has run past the highest address, the block returns ones until the next bus reset.

Top module: `rdeng_top`

## Requirements
- R1: After `rst_n` is released, and after any `bus_reset_i` pulse, `tx_en_o` is 0, `tx_bit_o` is 1 and `mem_rd_o` is 0.
- R2: After `start_i`, the block takes eight write slots as the opcode, least significant bit first. If the opcode equals 8'h69, it takes the next eight write slots as the start address, also least significant bit first.
- R3: Slots are at least 4 clock cycles apart. Two clock cycles after the slot that carries the address's most significant bit, `tx_en_o` is 1 and `tx_bit_o` equals bit 0 of the byte at the start address.
- R4: Each read slot advances the output by one bit, from bit 0 up to bit 7 of the byte. After the slot for bit 7, the byte at the next address is fetched, and its bit 0 is presented for the next slot.
- R5: After the slot for bit 7 of the byte at address 8'hFF, the address does not wrap: no further memory read is issued, and every later read slot returns 1 until a bus reset.
- R6: A `bus_reset_i` pulse between any two slots ends the command. A following `start_i` starts a fresh command that reads correctly.
- R7: Any opcode other than 8'h69 makes the block ignore all slots until the next bus reset: `tx_en_o` stays 0 and no memory read is issued.
- R8: `mem_rd_o` is a single-cycle pulse qualified by `mem_addr_o`. The memory returns the byte on `mem_data_i` one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: a reset pulse was detected on the bus |
| start_i | input | 1 | One-cycle pulse: the address layer has selected this slave |
| slot_i | input | 1 | One-cycle strobe per bit slot |
| wr_bit_i | input | 1 | Master's bit, sampled with `slot_i` in write slots |
| tx_en_o | output | 1 | The block drives read slots (data phase) |
| tx_bit_o | output | 1 | Bit to return in the next read slot; 1 when not driving |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 8 | Memory read address |
| mem_data_i | input | 8 | Memory read data, valid one cycle after `mem_rd_o` |

## Verification
Suppose the bit counter or the address counter drifts by a single step. The next byte returned at the ports is then rotated, or comes from a neighbouring address. That difference appears within one byte, that is within eight read slots. A wrong fetch pipeline shows sooner: `tx_bit_o` fails to hold bit 0 of the start byte two cycles after the address's last bit. A wrongly held overflow state or halt state shows on the next read slot. It appears either as a 0 where only ones may appear, or as a memory read strobe where none is allowed.

// File: rtl/rdeng_pkg.sv
package rdeng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPC  = 3'd1,
    ST_ADR  = 3'd2,
    ST_DATA = 3'd3,
    ST_HALT = 3'd4
  } rd_state_e;

  // next state of the command sequencer, bus reset has priority
  function automatic rd_state_e seq_next(input rd_state_e cur, input logic bus_rst,
                                         input logic start, input logic opc_done,
                                         input logic opc_ok, input logic adr_done);
    rd_state_e nxt;
    nxt = cur;
    if (bus_rst) nxt = ST_IDLE;
    else begin
      case (cur)
        ST_IDLE: if (start) nxt = ST_OPC;
        ST_OPC:  if (opc_done) nxt = opc_ok ? ST_ADR : ST_HALT;
        ST_ADR:  if (adr_done) nxt = ST_DATA;
        default: nxt = cur;
      endcase
    end
    return nxt;
  endfunction
endpackage

// File: rtl/rdeng_rx_byte.sv
module rdeng_rx_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] value_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  // least significant bit arrives first: new bit enters at the top
  function automatic logic [W-1:0] lsb_first_insert(input logic [W-1:0] v, input logic b);
    return {b, v[W-1:1]};
  endfunction

  assign value_o = lsb_first_insert(sh_q, bit_i);
  assign done_o  = en_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (en_i) begin
      sh_q  <= value_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rdeng_addr_ctr.sv
module rdeng_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          ovf_o,
  output logic          fetch_o,
  output logic          at_max_o
);
  logic [AW-1:0] addr_q;
  logic          ovf_q;
  logic          fetch_q;

  function automatic logic is_top(input logic [AW-1:0] a);
    return &a;
  endfunction

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign at_max_o = is_top(addr_q);
  assign addr_o   = addr_q;
  assign ovf_o    = ovf_q;
  assign fetch_o  = fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ovf_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else if (clr_i) begin
      ovf_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (load_i) begin
        addr_q  <= load_val_i;
        ovf_q   <= 1'b0;
        fetch_q <= 1'b1;
      end else if (step_i && !ovf_q) begin
        if (at_max_o) begin
          ovf_q <= 1'b1;
        end else begin
          addr_q  <= addr_inc(addr_q);
          fetch_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdeng_tx_shift.sv
module rdeng_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          last_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign bit_o  = sh_q[0];
  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else begin
      if (load_i) sh_q <= data_i;
      else if (shift_i) sh_q <= {1'b1, sh_q[DW-1:1]};
      if (shift_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rdeng_top.sv
module rdeng_top #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  READ_OPC = 8'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset_i,
  input  logic          start_i,
  input  logic          slot_i,
  input  logic          wr_bit_i,
  output logic          tx_en_o,
  output logic          tx_bit_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i
);
  import rdeng_pkg::*;

  localparam logic [CMD_W-1:0] OPC = CMD_W'(READ_OPC);

  rd_state_e      state_q;
  logic           opc_en, adr_en, opc_done, adr_done;
  logic [CMD_W-1:0] opc_val;
  logic [AW-1:0]  adr_val;
  logic           data_slot, byte_end, addr_max, ovf_q, load_q;
  logic           tx_lsb, tx_last, rx_clr;

  assign opc_en    = slot_i && (state_q == ST_OPC);
  assign adr_en    = slot_i && (state_q == ST_ADR);
  assign data_slot = slot_i && (state_q == ST_DATA);
  assign byte_end  = data_slot && tx_last;
  assign rx_clr    = bus_reset_i || start_i;

  rdeng_rx_byte #(.W(CMD_W)) opc_rx_i (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .en_i(opc_en),
    .bit_i(wr_bit_i), .done_o(opc_done), .value_o(opc_val)
  );

  rdeng_rx_byte #(.W(AW)) adr_rx_i (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .en_i(adr_en),
    .bit_i(wr_bit_i), .done_o(adr_done), .value_o(adr_val)
  );

  rdeng_addr_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(bus_reset_i),
    .load_i(adr_done), .load_val_i(adr_val), .step_i(byte_end),
    .addr_o(mem_addr_o), .ovf_o(ovf_q), .fetch_o(mem_rd_o), .at_max_o(addr_max)
  );

  rdeng_tx_shift #(.DW(DW)) tx_i (
    .clk(clk), .rst_n(rst_n), .clr_i(bus_reset_i || adr_done),
    .load_i(load_q), .data_i(mem_data_i), .shift_i(data_slot),
    .bit_o(tx_lsb), .last_o(tx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      load_q  <= 1'b0;
    end else begin
      state_q <= seq_next(state_q, bus_reset_i, start_i, opc_done,
                          (opc_val == OPC), adr_done);
      load_q  <= mem_rd_o && !bus_reset_i;
    end
  end

  assign tx_en_o  = (state_q == ST_DATA);
  assign tx_bit_o = tx_en_o ? (ovf_q | tx_lsb) : 1'b1;
endmodule

// File: rtl/rdeng_chk.sv
module rdeng_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_reset_i,
  input logic                 tx_en_o,
  input logic                 tx_bit_o,
  input logic                 mem_rd_o,
  input logic [AW-1:0]        mem_addr_o,
  input logic [DW-1:0]        mem_data_i,
  input rdeng_pkg::rd_state_e state_q,
  input logic                 ovf_q,
  input logic                 load_q,
  input logic                 byte_end,
  input logic                 addr_max
);
  import rdeng_pkg::*;

  p_idle_after_busrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (!tx_en_o && tx_bit_o && !mem_rd_o));

  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !ovf_q && !bus_reset_i && state_q == ST_DATA)
      |=> (tx_en_o && tx_bit_o == $past(mem_data_i[0])));

  p_step_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !addr_max && !ovf_q && !bus_reset_i)
      |=> (mem_rd_o && mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && addr_max && !bus_reset_i) |=> (ovf_q && !mem_rd_o));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !bus_reset_i) |=> ovf_q);

  p_ones_after_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && ovf_q) |-> tx_bit_o);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !bus_reset_i) |=> (state_q == ST_HALT && !tx_en_o && !mem_rd_o));

  p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
endmodule

bind rdeng_top rdeng_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .tx_en_o(tx_en_o),
  .tx_bit_o(tx_bit_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .mem_data_i(mem_data_i), .state_q(state_q), .ovf_q(ovf_q), .load_q(load_q),
  .byte_end(byte_end), .addr_max(addr_max)
);

// File: tb/rdeng_tb_top.sv
module rdeng_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset_i = 1'b0, start_i = 1'b0, slot_i = 1'b0, wr_bit_i = 1'b0;
  logic       tx_en_o, tx_bit_o, mem_rd_o;
  logic [7:0] mem_addr_o;
  logic [7:0] mem_data_i = 8'h00;

  int total = 0, fails = 0, rd_cnt = 0, dbl_cnt = 0;
  logic prev_rd = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  rdeng_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .start_i(start_i),
    .slot_i(slot_i), .wr_bit_i(wr_bit_i), .tx_en_o(tx_en_o), .tx_bit_o(tx_bit_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    logic [7:0] m;
    m = a * 8'd37;
    return m ^ 8'h5A;
  endfunction

  // memory model: one cycle of latency; also watch strobe shape (R8)
  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_data_i <= pat(mem_addr_o);
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_rd_o && prev_rd) dbl_cnt <= dbl_cnt + 1;
    prev_rd <= mem_rd_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(posedge clk); @(negedge clk); s = 1'b0;
  endtask

  task automatic wr_slot(input logic b);
    repeat (3) @(posedge clk);
    @(negedge clk); wr_bit_i = b; slot_i = 1'b1;
    @(posedge clk); @(negedge clk); slot_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_slot(v[i]);
  endtask

  task automatic rd_byte(output logic [7:0] v, output bit drove);
    drove = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      v[i] = tx_bit_o;
      drove = drove & tx_en_o;
      slot_i = 1'b1;
      @(posedge clk); @(negedge clk); slot_i = 1'b0;
    end
  endtask

  task automatic busrst();
    pulse(bus_reset_i);
  endtask

  // start, opcode, address, then sample the first bit two cycles later (R3)
  task automatic open_read(input logic [7:0] a, input string tag);
    start_i = 1'b0;
    pulse(start_i);
    wr_byte(8'h69);
    wr_byte(a);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(tx_en_o && tx_bit_o == pat(a)[0], tag, {tx_en_o, tx_bit_o}, {1'b1, pat(a)[0]});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    logic [7:0] b;
    bit dr;
    int snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!tx_en_o && tx_bit_o && !mem_rd_o, "R1 reset", {tx_en_o, tx_bit_o, mem_rd_o}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_en_o && tx_bit_o, "R1 after release", {tx_en_o, tx_bit_o}, 2'b01);

    // R2/R3/R4/R5: sweep every start address, two bytes each
    for (int a = 0; a < 256; a++) begin
      open_read(8'(a), "R3 first bit");
      rd_byte(b, dr);
      chk(dr && b == pat(8'(a)), "R2 R4 byte at start", b, pat(8'(a)));
      rd_byte(b, dr);
      if (a == 255) chk(dr && b == 8'hFF, "R5 past top", b, 8'hFF);
      else chk(dr && b == pat(8'(a + 1)), "R4 next byte", b, pat(8'(a + 1)));
      busrst();
      @(negedge clk);
      chk(!tx_en_o && tx_bit_o, "R1 R6 after bus reset", {tx_en_o, tx_bit_o}, 2'b01);
    end

    // R5: cross the top, then many ones and no extra fetch
    open_read(8'hFE, "R3 first bit FE");
    snap = rd_cnt;
    rd_byte(b, dr); chk(b == pat(8'hFE), "R4 FE", b, pat(8'hFE));
    rd_byte(b, dr); chk(b == pat(8'hFF), "R4 FF", b, pat(8'hFF));
    for (int k = 0; k < 3; k++) begin
      rd_byte(b, dr); chk(dr && b == 8'hFF, "R5 ones", b, 8'hFF);
    end
    chk(rd_cnt == snap + 1, "R5 no wrap fetch", rd_cnt - snap, 1);
    busrst();

    // R6: reset mid-byte, then a fresh command
    open_read(8'h40, "R3 first bit 40");
    for (int i = 0; i < 3; i++) wr_slot(1'b0);
    busrst();
    @(negedge clk);
    chk(!tx_en_o && tx_bit_o && !mem_rd_o, "R6 abort mid-byte", {tx_en_o, tx_bit_o}, 2'b01);
    open_read(8'h41, "R6 R3 restart");
    rd_byte(b, dr); chk(b == pat(8'h41), "R6 restart byte", b, pat(8'h41));
    busrst();

    // R6: reset in the middle of the address
    pulse(start_i);
    wr_byte(8'h69);
    for (int i = 0; i < 5; i++) wr_slot(1'b1);
    busrst();
    open_read(8'h07, "R6 after address abort");
    rd_byte(b, dr); chk(b == pat(8'h07), "R6 byte 07", b, pat(8'h07));
    busrst();

    // R7: foreign opcodes make the block ignore slots
    for (int k = 0; k < 3; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'hCC : (k == 1) ? 8'h68 : 8'hE9;
      snap = rd_cnt;
      pulse(start_i);
      wr_byte(op);
      wr_byte(8'h20);
      rd_byte(b, dr);
      chk(!dr && !tx_en_o, "R7 no drive", tx_en_o, 0);
      chk(rd_cnt == snap, "R7 no fetch", rd_cnt - snap, 0);
      busrst();
    end
    open_read(8'h20, "R7 recovery");
    rd_byte(b, dr); chk(b == pat(8'h20), "R7 recovery byte", b, pat(8'h20));
    busrst();

    // R8: strobe always single-cycle
    chk(dbl_cnt == 0, "R8 single pulse", dbl_cnt, 0);

    done = 1'b1;
    report();
  end
endmodule